// File: doc/BRIEF.md
# Dual-Channel DDR IQ Sample Deframer

This block sits at the receive pins of a radio transceiver. The transceiver sends 12-bit sample words on a double-data-rate bus, together with its own clock and a frame strobe. The block takes one word on each falling edge and one on each rising edge of that clock. It uses the strobe to find where each group of words begins. It then presents the samples as parallel I and Q words for up to two channels. The transceiver clock is passed straight through as the radio clock, and every parallel output is registered on its rising edge.

A mode input selects between two framings. In single-channel mode, one I/Q pair arrives in each clock period. In two-channel mode, a set of four words spans two periods. The first pair of the set goes to the channel-1 outputs and the second pair to the channel-0 outputs. A one-cycle valid strobe marks every completed pair or set, and all outputs of that set change in the same cycle.

Top module: `ddr_iq_deframer`

## Requirements
- R1: `radio_clk` is a direct copy of `rx_clk`.
- R2: While `rst` is high at a rising edge of `rx_clk`, every sample output and `smp_valid` are cleared to zero by that edge.
- R3: In single-channel mode (`two_chan`=0), a word stable across a falling edge with `rx_frame`=1, followed by a word stable across the next rising edge with `rx_frame`=0, is presented as `ch0_i` (first word) and `ch0_q` (second word) from that rising edge. `smp_valid` is high for that one cycle.
- R4: Every set delivered in single-channel mode drives `ch1_i` and `ch1_q` to zero.
- R5: In two-channel mode (`two_chan`=1), the four words are received in this order: strobe high, high, low, low. Words 1 and 2 appear on `ch1_i`/`ch1_q` and words 3 and 4 on `ch0_i`/`ch0_q`. All four update together at the rising edge that captures word 4. There is one valid cycle per set, and it is never followed directly by another valid cycle.
- R6: A group is accepted only if the strobe sampled with its first word is high and the strobe sampled with the word just before it was low. Words received after reset and before the first such low-to-high change are discarded.
- R7: In two-channel mode, if the second pair of a set does not carry a low strobe on both words, the whole partial set is dropped and the outputs keep their old values. The next set is accepted only after a fresh low-to-high strobe change.
- R8: In single-channel mode, a pair whose strobe stays high over the second word is dropped. The pair after it is also dropped, because no low-to-high change precedes it.
- R9: `two_chan` is taken only during reset or between sets. A change in the middle of a two-channel set does not affect that set.
- R10: The sample outputs change only in cycles where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, synchronous to `rx_clk` |
| two_chan | input | 1 | 0 = single-channel framing, 1 = two-channel framing |
| rx_clk | input | 1 | Source-synchronous clock from the transceiver |
| rx_frame | input | 1 | Frame strobe, sampled on both edges |
| rx_data | input | 12 | DDR sample word bus |
| radio_clk | output | 1 | Radio clock, equal to `rx_clk` |
| ch0_i | output | 12 | Channel-0 I sample |
| ch0_q | output | 12 | Channel-0 Q sample |
| ch1_i | output | 12 | Channel-1 I sample (zero in single-channel mode) |
| ch1_q | output | 12 | Channel-1 Q sample (zero in single-channel mode) |
| smp_valid | output | 1 | One-cycle strobe per completed pair or set |

## Verification
Each single-channel pair and each two-channel set uses distinct words, so that a swap between I and Q, between the channels, or between the rising and falling captures shows up as a data mismatch. The run starts with the strobe held high through reset, which shows whether the block waits for a real low-to-high change. Broken strobe sequences in both modes are followed by idle periods, which shows whether a partial set is dropped and whether the outputs hold. Switching the mode between sets and in the middle of a set shows whether the mode is taken at the right moment.

// File: rtl/ddr_iq_deframer.sv
`timescale 1ns/1ps
module ddr_iq_deframer #(
  parameter int W = 12
) (
  input  logic         rst,
  input  logic         two_chan,
  input  logic         rx_clk,
  input  logic         rx_frame,
  input  logic [W-1:0] rx_data,
  output logic         radio_clk,
  output logic [W-1:0] ch0_i,
  output logic [W-1:0] ch0_q,
  output logic [W-1:0] ch1_i,
  output logic [W-1:0] ch1_q,
  output logic         smp_valid
);

  assign radio_clk = rx_clk;

  logic [W-1:0] fall_word;
  logic         fall_frame;

  always_ff @(negedge rx_clk) begin
    fall_word  <= rx_data;
    fall_frame <= rx_frame;
  end

  logic         prev_frame;
  logic         mode_q;
  logic         half_done;
  logic [W-1:0] hold_i;
  logic [W-1:0] hold_q;

  wire lead      = fall_frame & ~prev_frame;
  wire siso_ok   = lead & ~rx_frame;
  wire mimo_head = lead & rx_frame;
  wire mimo_tail = ~fall_frame & ~rx_frame;

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      prev_frame <= 1'b1;
      mode_q     <= two_chan;
      half_done  <= 1'b0;
      hold_i     <= '0;
      hold_q     <= '0;
      ch0_i      <= '0;
      ch0_q      <= '0;
      ch1_i      <= '0;
      ch1_q      <= '0;
      smp_valid  <= 1'b0;
    end else begin
      prev_frame <= rx_frame;
      smp_valid  <= 1'b0;
      if (!half_done) mode_q <= two_chan;
      if (!mode_q) begin
        half_done <= 1'b0;
        if (siso_ok) begin
          ch0_i     <= fall_word;
          ch0_q     <= rx_data;
          ch1_i     <= '0;
          ch1_q     <= '0;
          smp_valid <= 1'b1;
        end
      end else if (half_done) begin
        half_done <= 1'b0;
        if (mimo_tail) begin
          ch1_i     <= hold_i;
          ch1_q     <= hold_q;
          ch0_i     <= fall_word;
          ch0_q     <= rx_data;
          smp_valid <= 1'b1;
        end
      end else if (mimo_head) begin
        hold_i    <= fall_word;
        hold_q    <= rx_data;
        half_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_iq_deframer_chk.sv
`timescale 1ns/1ps
module ddr_iq_deframer_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         rx_frame,
  input logic         mode_q,
  input logic         half_done,
  input logic [W-1:0] ch0_i,
  input logic [W-1:0] ch0_q,
  input logic [W-1:0] ch1_i,
  input logic [W-1:0] ch1_q,
  input logic         smp_valid
);

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!smp_valid && ch0_i == '0 && ch0_q == '0 && ch1_i == '0 && ch1_q == '0));

  assert_ch1_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !$past(mode_q)) |-> (ch1_i == '0 && ch1_q == '0));

  assert_set_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && $past(mode_q)) |=> !smp_valid);

  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> !$past(rx_frame));

  assert_mode_lock_R9: assert property (@(posedge clk) disable iff (rst)
    half_done |=> $stable(mode_q));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> $stable({ch0_i, ch0_q, ch1_i, ch1_q}));

endmodule

bind ddr_iq_deframer ddr_iq_deframer_chk #(.W(W)) u_chk (
  .clk(rx_clk), .rst(rst), .rx_frame(rx_frame), .mode_q(mode_q),
  .half_done(half_done), .ch0_i(ch0_i), .ch0_q(ch0_q), .ch1_i(ch1_i),
  .ch1_q(ch1_q), .smp_valid(smp_valid)
);

// File: tb/ddr_iq_deframer_tb.sv
`timescale 1ns/1ps
module ddr_iq_deframer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        two_chan = 1'b0;
  logic        rx_frame = 1'b1;
  logic [11:0] rx_data = '0;
  logic        radio_clk, smp_valid;
  logic [11:0] ch0_i, ch0_q, ch1_i, ch1_q;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [47:0] expq[$];
  string       tagq[$];
  logic [47:0] last_set = '0;

  always #2.5 clk = ~clk;

  ddr_iq_deframer u_dut (
    .rst(rst), .two_chan(two_chan), .rx_clk(clk), .rx_frame(rx_frame),
    .rx_data(rx_data), .radio_clk(radio_clk), .ch0_i(ch0_i), .ch0_q(ch0_q),
    .ch1_i(ch1_i), .ch1_q(ch1_q), .smp_valid(smp_valid)
  );

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_pair(logic [11:0] a, logic fa, logic [11:0] b, logic fb);
    @(posedge clk); #1;
    rx_data = a; rx_frame = fa;
    @(negedge clk); #1;
    rx_data = b; rx_frame = fb;
  endtask

  task automatic siso(string tag, logic [11:0] i, logic [11:0] q);
    send_pair(i, 1'b1, q, 1'b0);
    expq.push_back({i, q, 24'h0});
    tagq.push_back(tag);
    last_set = {i, q, 24'h0};
  endtask

  task automatic mimo(string tag, logic [11:0] i1, logic [11:0] q1,
                      logic [11:0] i0, logic [11:0] q0);
    send_pair(i1, 1'b1, q1, 1'b1);
    send_pair(i0, 1'b0, q0, 1'b0);
    expq.push_back({i0, q0, i1, q1});
    tagq.push_back(tag);
    last_set = {i0, q0, i1, q1};
  endtask

  task automatic idle();
    send_pair(12'h0, 1'b0, 12'h0, 1'b0);
  endtask

  task automatic settle_and_hold(string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({tag, " outputs hold"}, {ch0_i, ch0_q, ch1_i, ch1_q}, last_set);
    check({tag, " queue drained"}, 48'(expq.size()), 48'd0);
  endtask

  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      if (expq.size() == 0) begin
        check("unexpected valid (R6/R7/R8)", {ch0_i, ch0_q, ch1_i, ch1_q}, 48'hx);
      end else begin
        automatic logic [47:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        check(t, {ch0_i, ch0_q, ch1_i, ch1_q}, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 reset outputs", {ch0_i, ch0_q, ch1_i, ch1_q}, 48'h0);
    check("R2 reset valid", 48'(smp_valid), 48'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #0.5;
      check("R1 radio_clk high", 48'(radio_clk), 48'd1);
      @(negedge clk); #0.5;
      check("R1 radio_clk low", 48'(radio_clk), 48'd0);
    end

    @(posedge clk); #1;
    rst = 0;
    rx_data = 12'hBAD; rx_frame = 1'b1;
    @(negedge clk); #1;
    rx_data = 12'hBAE; rx_frame = 1'b0;

    siso("R3 siso pair 0", 12'h123, 12'h456);
    siso("R3 siso pair 1", 12'hA5A, 12'h5A5);
    siso("R4 siso pair 2", 12'hFFF, 12'h000);
    siso("R3 siso pair 3", 12'h001, 12'h800);
    siso("R4 siso pair 4", 12'h7E1, 12'h18E);
    settle_and_hold("R6 first pair discarded");

    send_pair(12'h321, 1'b1, 12'h654, 1'b1);
    send_pair(12'h111, 1'b1, 12'h222, 1'b0);
    settle_and_hold("R8 siso bad strobe");
    idle();
    siso("R8 siso after realign", 12'h9C3, 12'h3C9);

    two_chan = 1'b1;
    idle();
    mimo("R5 mimo set 0", 12'hA01, 12'hB01, 12'hC01, 12'hD01);
    mimo("R5 mimo set 1", 12'hA02, 12'hB02, 12'hC02, 12'hD02);
    mimo("R5 mimo set 2", 12'h0F0, 12'hF0F, 12'h333, 12'hCCC);

    send_pair(12'hE01, 1'b1, 12'hE02, 1'b1);
    send_pair(12'hE03, 1'b0, 12'hE04, 1'b1);
    settle_and_hold("R7 mimo broken tail");
    idle();
    mimo("R7 mimo after realign", 12'h1A1, 12'h2B2, 12'h3C3, 12'h4D4);
    send_pair(12'hE05, 1'b1, 12'hE06, 1'b1);
    send_pair(12'hE07, 1'b1, 12'hE08, 1'b1);
    settle_and_hold("R7 mimo double head");
    idle();

    send_pair(12'h5A1, 1'b1, 12'h5B1, 1'b1);
    @(posedge clk); #1;
    two_chan = 1'b0;
    rx_data = 12'h5C1; rx_frame = 1'b0;
    @(negedge clk); #1;
    rx_data = 12'h5D1;
    expq.push_back({12'h5C1, 12'h5D1, 12'h5A1, 12'h5B1});
    tagq.push_back("R9 mode change mid-set");
    last_set = {12'h5C1, 12'h5D1, 12'h5A1, 12'h5B1};
    idle();
    idle();
    siso("R4 siso after mimo", 12'h246, 12'h8AC);
    settle_and_hold("R10 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule